// File: doc/BRIEF.md
# Host Command and Status Register with Event Latching

This block is a single 16-bit register as the host sees it. A host write is not stored as a data word. Each written bit acts as a command strobe. Every stored flag has one bit that sets it and a neighbouring bit that clears it. Writing a 0 leaves the flag as it is. When both bits of a pair are written as 1, the flag is cleared.

A host read returns a packed status word. It holds the stored flags, two sticky event bits and live lines from a protocol controller. The two event bits capture narrow interrupt pulses from the controller. Each pulse is synchronised into the register clock and edge-detected. The bit then stays set until the host clears it.

The block has four further outputs:
- a gated interrupt request for the host;
- a stretched master-reset pulse for the controller;
- a timer clock whose rate is chosen by one of the flags;
- the host page and page-switch-enable bits, which separate page-switching logic consumes.

Top module: `hostctl_reg`

## Requirements
- R1: Read word layout:
  - bit 0: message event;
  - bit 1: failure event;
  - bit 2: interrupt enable;
  - bit 4: subsystem flag;
  - bit 6: `term_active_i`;
  - bit 7: `ready_i`;
  - bit 8: timer-rate select;
  - bit 12: host page;
  - bit 13: `ctrl_page_i`;
  - bit 14: page-switch enable;
  - bits 15, 11, 10, 9, 5 and 3 always read 0.
- R2: Write set/clear pairs:
  - interrupt enable: set bit 2, clear bit 3;
  - subsystem flag: set bit 4, clear bit 5;
  - timer-rate select: set bit 8, clear bit 9;
  - host page: set bit 12, clear bit 13;
  - page-switch enable: set bit 14, clear bit 15.

  A write takes effect at the clock edge that samples it. A 0 in a command bit leaves state unchanged.
- R3: When the set bit and the clear bit of one pair are both 1 in a single write, the flag becomes 0.
- R4: A rising edge on `msg_pulse_i` sets read bit 0, and a rising edge on `fail_pulse_i` sets read bit 1. Each edge passes through SYNC_STAGES synchroniser flops and then an edge detector. Each bit stays 1 until a write with bit 0 (message) or bit 1 (failure) set to 1. A new edge detected in the same cycle as a clear keeps the bit at 1.
- R5: `irq_o` is 1 only when interrupt enable is 1 and at least one event bit is 1. With REG_IRQ=1 it follows that condition one cycle later.
- R6: A write with bit 7 set drives `ctrl_reset_o` high for exactly RST_CYCLES cycles, starting the cycle after the write. The read word is not changed by it.
- R7: A set of page-switch enable takes effect only while `monitor_mode_i` is 1. Its clear works in any mode. `page_sw_en_o` mirrors the flag.
- R8: With timer-rate select at 0, `timer_clk_o` is a square wave with a period of 2*BASE_HALF clock cycles.
- R9: With timer-rate select at 1, the `timer_clk_o` period is SLOW_RATIO times longer, which is 2*BASE_HALF*SLOW_RATIO cycles.
- R10: After reset, every stored flag and event bit is 0, `irq_o` is 0 and `ctrl_reset_o` is 0.
- R11: `host_page_o` and `subsys_flag_o` mirror their stored flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe, one cycle per write |
| wr_data_i | input | 16 | Host command word |
| rd_data_o | output | 16 | Packed status word |
| msg_pulse_i | input | 1 | Message interrupt pulse from controller |
| fail_pulse_i | input | 1 | Failure interrupt pulse from controller |
| term_active_i | input | 1 | Controller busy with a command |
| ready_i | input | 1 | Controller initialised |
| ctrl_page_i | input | 1 | Page currently used by the controller |
| monitor_mode_i | input | 1 | Controller configured as bus monitor |
| irq_o | output | 1 | Host interrupt request |
| ctrl_reset_o | output | 1 | Stretched master reset to controller |
| timer_clk_o | output | 1 | Selected timer clock |
| subsys_flag_o | output | 1 | Subsystem flag to controller |
| host_page_o | output | 1 | Host page select |
| page_sw_en_o | output | 1 | Page switching enabled |

## Verification
The bench builds the block with BASE_HALF=2, SLOW_RATIO=256, RST_CYCLES=4, SYNC_STAGES=2 and REG_IRQ=1.

With these values:
- The fast timer period is 4 cycles and the divided period is 1024 cycles, so both rates can be measured edge to edge in a short run.
- The reset stretch is short enough to count exactly.
- With a two-flop synchroniser, the bench can place a clear write in exactly the cycle where a new edge reaches the event latch, which tests the priority rule of R4.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
   localparam int unsigned WORD_W = 16;
   localparam int unsigned NFLAG  = 5;
   localparam int unsigned NEVT   = 2;

   localparam int unsigned F_IE   = 0;
   localparam int unsigned F_SUB  = 1;
   localparam int unsigned F_TRES = 2;
   localparam int unsigned F_HPG  = 3;
   localparam int unsigned F_PSE  = 4;

   localparam int unsigned B_TACT = 6;
   localparam int unsigned B_RDY  = 7;
   localparam int unsigned B_MRST = 7;
   localparam int unsigned B_CPG  = 13;

   // set-command bit of a flag; the clear bit sits one above it,
   // and the flag reads back at the same position as its set bit
   function automatic int unsigned flag_pos(input int unsigned f);
      case (f)
         F_IE:    flag_pos = 2;
         F_SUB:   flag_pos = 4;
         F_TRES:  flag_pos = 8;
         F_HPG:   flag_pos = 12;
         default: flag_pos = 14;
      endcase
   endfunction
endpackage

// File: rtl/hsc_sr_flag.sv
module hsc_sr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (clr_i) q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
   end
endmodule

// File: rtl/hsc_evt_latch.sv
module hsc_evt_latch #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_i,
   input  logic clr_i,
   output logic sticky_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pulse_i};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_o <= 1'b0;
      else        sticky_o <= rise | (sticky_o & ~clr_i);
   end
endmodule

// File: rtl/hsc_rst_stretch.sv
module hsc_rst_stretch #(
   parameter int unsigned RST_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic pulse_o
);
   localparam int unsigned CW = $clog2(RST_CYCLES + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (fire_i)        cnt_q <= CW'(RST_CYCLES);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/hsc_tmr_clk.sv
module hsc_tmr_clk #(
   parameter int unsigned BASE_HALF  = 200,
   parameter int unsigned SLOW_RATIO = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_sel_i,
   output logic tclk_o
);
   localparam int unsigned BW = (BASE_HALF  > 1) ? $clog2(BASE_HALF)  : 1;
   localparam int unsigned PW = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;

   logic [BW-1:0] base_q;
   logic [PW-1:0] pre_q;
   logic          fast_q, slow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         pre_q  <= '0;
         fast_q <= 1'b0;
         slow_q <= 1'b0;
      end else if (base_q == BW'(BASE_HALF - 1)) begin
         base_q <= '0;
         fast_q <= ~fast_q;
         if (pre_q == PW'(SLOW_RATIO - 1)) begin
            pre_q  <= '0;
            slow_q <= ~slow_q;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end else begin
         base_q <= base_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tclk_o <= 1'b0;
      else        tclk_o <= slow_sel_i ? slow_q : fast_q;
   end
endmodule

// File: rtl/hostctl_reg.sv
module hostctl_reg #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BASE_HALF   = 200,
   parameter int unsigned SLOW_RATIO  = 256,
   parameter int unsigned RST_CYCLES  = 4,
   parameter bit          REG_IRQ     = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en_i,
   input  logic [15:0] wr_data_i,
   output logic [15:0] rd_data_o,
   input  logic        msg_pulse_i,
   input  logic        fail_pulse_i,
   input  logic        term_active_i,
   input  logic        ready_i,
   input  logic        ctrl_page_i,
   input  logic        monitor_mode_i,
   output logic        irq_o,
   output logic        ctrl_reset_o,
   output logic        timer_clk_o,
   output logic        subsys_flag_o,
   output logic        host_page_o,
   output logic        page_sw_en_o
);
   import hsc_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (BASE_HALF < 1) begin : g_bad_base
      $error("BASE_HALF must be at least 1");
   end
   if (SLOW_RATIO < 2) begin : g_bad_ratio
      $error("SLOW_RATIO must be at least 2");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be at least 1");
   end

   logic [NFLAG-1:0] flag_q;
   logic [NEVT-1:0]  evt_q;
   logic [NEVT-1:0]  evt_in;
   logic             irq_cond;
   logic             unused_wr;

   assign evt_in    = {fail_pulse_i, msg_pulse_i};
   assign unused_wr = ^{wr_data_i[6], wr_data_i[11:10]};

   for (genvar g = 0; g < NFLAG; g++) begin : g_flag
      localparam int unsigned SP = flag_pos(g);
      logic set_w;
      if (g == F_PSE) begin : g_gated
         assign set_w = wr_en_i & wr_data_i[SP] & monitor_mode_i;
      end else begin : g_plain
         assign set_w = wr_en_i & wr_data_i[SP];
      end
      hsc_sr_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_w),
         .clr_i (wr_en_i & wr_data_i[SP+1]),
         .q_o   (flag_q[g])
      );
   end

   for (genvar e = 0; e < NEVT; e++) begin : g_evt
      hsc_evt_latch #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
         .clk      (clk),
         .rst_n    (rst_n),
         .pulse_i  (evt_in[e]),
         .clr_i    (wr_en_i & wr_data_i[e]),
         .sticky_o (evt_q[e])
      );
   end

   assign irq_cond = flag_q[F_IE] & (|evt_q);

   if (REG_IRQ) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_cond;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_cond;
   end

   hsc_rst_stretch #(.RST_CYCLES(RST_CYCLES)) u_mrst (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (wr_en_i & wr_data_i[B_MRST]),
      .pulse_o (ctrl_reset_o)
   );

   hsc_tmr_clk #(.BASE_HALF(BASE_HALF), .SLOW_RATIO(SLOW_RATIO)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .slow_sel_i (flag_q[F_TRES]),
      .tclk_o     (timer_clk_o)
   );

   always_comb begin
      rd_data_o = '0;
      rd_data_o[NEVT-1:0] = evt_q;
      for (int f = 0; f < NFLAG; f++) begin
         rd_data_o[flag_pos(f)] = flag_q[f];
      end
      rd_data_o[B_TACT] = term_active_i;
      rd_data_o[B_RDY]  = ready_i;
      rd_data_o[B_CPG]  = ctrl_page_i;
   end

   assign subsys_flag_o = flag_q[F_SUB];
   assign host_page_o   = flag_q[F_HPG];
   assign page_sw_en_o  = flag_q[F_PSE];
endmodule

// File: rtl/hostctl_reg_chk.sv
module hostctl_reg_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       clr_msg,
   input logic       ie_set,
   input logic       ie_clr,
   input logic       mrst_cmd,
   input logic       mon_mode,
   input logic       st_msg,
   input logic       st_ie,
   input logic       st_pse,
   input logic [5:0] st_resv,
   input logic       irq,
   input logic       mrst_out
);
   AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) st_resv == 6'd0); // R1
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && ie_set && ie_clr) |=> !st_ie); // R3
   AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (st_msg && !(wr_en && clr_msg)) |=> st_msg); // R4
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) (!st_ie && !$past(st_ie)) |-> !irq); // R5
   AST_MRST_START: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && mrst_cmd) |=> mrst_out); // R6
   AST_PSE_MONITOR: assert property (@(posedge clk) disable iff (!rst_n) $rose(st_pse) |-> $past(mon_mode)); // R7
endmodule

bind hostctl_reg hostctl_reg_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en_i),
   .clr_msg  (wr_data_i[0]),
   .ie_set   (wr_data_i[2]),
   .ie_clr   (wr_data_i[3]),
   .mrst_cmd (wr_data_i[7]),
   .mon_mode (monitor_mode_i),
   .st_msg   (rd_data_o[0]),
   .st_ie    (rd_data_o[2]),
   .st_pse   (rd_data_o[14]),
   .st_resv  ({rd_data_o[15], rd_data_o[11:9], rd_data_o[5], rd_data_o[3]}),
   .irq      (irq_o),
   .mrst_out (ctrl_reset_o)
);

// File: tb/test_hostctl_reg.sv
`timescale 1ns/1ps
module test_hostctl_reg;
   localparam int unsigned BH = 2;
   localparam int unsigned SR = 256;
   localparam int unsigned RC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [15:0] wr_data_i = '0;
   logic [15:0] rd_data_o;
   logic        msg_pulse_i = 1'b0, fail_pulse_i = 1'b0;
   logic        term_active_i = 1'b0, ready_i = 1'b0, ctrl_page_i = 1'b0, monitor_mode_i = 1'b0;
   logic        irq_o, ctrl_reset_o, timer_clk_o, subsys_flag_o, host_page_o, page_sw_en_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   hostctl_reg #(.SYNC_STAGES(2), .BASE_HALF(BH), .SLOW_RATIO(SR),
                 .RST_CYCLES(RC), .REG_IRQ(1'b1)) i_hostctl_reg (.*);

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [15:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0; wr_data_i = '0;
   endtask

   task automatic t_reset;
      chk("R10 status", rd_data_o, 16'h0000);
      chk("R10 irq", {15'd0, irq_o}, 16'd0);
      chk("R10 mrst", {15'd0, ctrl_reset_o}, 16'd0);
   endtask

   task automatic t_live;
      @(negedge clk);
      term_active_i = 1'b1; ready_i = 1'b1; ctrl_page_i = 1'b1;
      #1 chk("R1 live lines", rd_data_o, 16'h20C0);
      @(negedge clk);
      term_active_i = 1'b0; ready_i = 1'b0; ctrl_page_i = 1'b0;
   endtask

   task automatic t_flags;
      host_wr(16'h1114);
      chk("R2 set flags", rd_data_o, 16'h1114);
      chk("R11 mirrors", {14'd0, host_page_o, subsys_flag_o}, 16'h0003);
      host_wr(16'h0000);
      chk("R2 zero write no effect", rd_data_o, 16'h1114);
      host_wr(16'hFFFF & ~16'h4000 & ~16'h8000 & ~16'h0080 & ~16'h0003);
      chk("R3 both bits clear all", rd_data_o, 16'h0000);
      host_wr(16'h0014);
      host_wr(16'h0020);
      chk("R2 clear subsystem only", rd_data_o, 16'h0004);
      host_wr(16'h000C);
      chk("R3 ie both bits", rd_data_o, 16'h0000);
      host_wr(16'h1000);
      host_wr(16'h3000);
      chk("R3 host page both bits", {15'd0, host_page_o}, 16'd0);
   endtask

   task automatic t_pse;
      monitor_mode_i = 1'b0;
      host_wr(16'h4000);
      chk("R7 set ignored outside monitor", rd_data_o, 16'h0000);
      monitor_mode_i = 1'b1;
      host_wr(16'h4000);
      chk("R7 set in monitor", {rd_data_o[14], page_sw_en_o}, 16'h0003);
      monitor_mode_i = 1'b0;
      host_wr(16'h8000);
      chk("R7 clear any mode", {rd_data_o[14], page_sw_en_o}, 16'h0000);
   endtask

   task automatic pulse(input bit which);
      @(negedge clk);
      if (which) fail_pulse_i = 1'b1; else msg_pulse_i = 1'b1;
      repeat (3) @(negedge clk);
      fail_pulse_i = 1'b0; msg_pulse_i = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_events;
      pulse(1'b0);
      chk("R4 msg latched", rd_data_o, 16'h0001);
      chk("R5 no irq when disabled", {15'd0, irq_o}, 16'd0);
      host_wr(16'h0004);
      @(negedge clk);
      chk("R5 irq when enabled", {15'd0, irq_o}, 16'd1);
      host_wr(16'h0002);
      chk("R4 other clear keeps msg", rd_data_o, 16'h0005);
      host_wr(16'h0001);
      @(negedge clk);
      chk("R4 msg cleared", rd_data_o, 16'h0004);
      chk("R5 irq drops", {15'd0, irq_o}, 16'd0);
      pulse(1'b1);
      chk("R4 fail latched", rd_data_o, 16'h0006);
      chk("R5 irq on fail", {15'd0, irq_o}, 16'd1);
      host_wr(16'h0002);
      host_wr(16'h0008);
      chk("R4 fail cleared", rd_data_o, 16'h0000);
   endtask

   task automatic t_race;
      pulse(1'b0);
      chk("R4 race setup", rd_data_o[0], 1'b1);
      @(negedge clk); msg_pulse_i = 1'b1;
      @(negedge clk);
      @(negedge clk); wr_en_i = 1'b1; wr_data_i = 16'h0001;
      @(negedge clk); wr_en_i = 1'b0; wr_data_i = '0; msg_pulse_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R4 event beats clear", rd_data_o[0], 1'b1);
      host_wr(16'h0001);
      chk("R4 plain clear", rd_data_o[0], 1'b0);
   endtask

   task automatic t_mrst;
      int hi = 0;
      host_wr(16'h0080);
      chk("R6 read unchanged", rd_data_o, 16'h0000);
      for (int i = 0; i < RC + 6; i++) begin
         if (i > 0) @(negedge clk);
         if (ctrl_reset_o) hi++;
      end
      chk("R6 pulse width", 16'(hi), 16'(RC));
   endtask

   task automatic period(output int n);
      logic pv;
      n = 0;
      pv = timer_clk_o;
      forever begin
         @(negedge clk);
         if (!pv && timer_clk_o) break;
         pv = timer_clk_o;
      end
      pv = timer_clk_o;
      forever begin
         @(negedge clk);
         n++;
         if (!pv && timer_clk_o) break;
         pv = timer_clk_o;
      end
   endtask

   task automatic t_timer;
      int n;
      period(n); period(n);
      chk("R8 fast period", 16'(n), 16'(2 * BH));
      host_wr(16'h0100);
      period(n); period(n);
      chk("R9 slow period", 16'(n), 16'(2 * BH * SR));
      host_wr(16'h0200);
      period(n); period(n);
      chk("R8 fast again", 16'(n), 16'(2 * BH));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset;
      t_live;
      t_flags;
      t_pse;
      t_events;
      t_race;
      t_mrst;
      t_timer;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule